// File: doc/BRIEF.md
# Serial Receiver with Sticky Error Flags

This block deserialises frames arriving on a single serial input line. A frame starts with a low START bit. Data bits follow, least significant first. An optional parity bit comes next, then a high STOP bit. When a frame completes, the byte is placed in a hold register and a full flag is raised for the host. The host acknowledges with a one-cycle read strobe: the active-low read enable and the active-low chip select are both low in the same cycle. That strobe empties the hold register and clears both error flags.

The receiver has two modes. In asynchronous mode the line is oversampled at 16 ticks per bit, and the tick rate comes from a programmable divider. A START bit counts only if the line is still low at its middle, so short glitches are ignored. In synchronous mode the sender shares the receiver's clock: a falling edge starts a frame, and every following clock carries one bit. The serial input always passes through a two-flop synchroniser first. The data width can be 7 or 8 bits. Parity can be off, odd or even. A parity mismatch and an overrun (a frame completing while the hold register is still full) are both recorded as sticky flags. On an overrun the held byte is kept and the new byte is dropped.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, data_o, rx_full_o, parity_err_o and overflow_o are all 0, and an idle high line produces no frame.
- R2: A completed frame loads its data bits into data_o, with the first received data bit in bit 0, and sets rx_full_o to 1.
- R3: rx_full_o stays 1 until a cycle with rd_n_i=0 and cs_n_i=0; rd_n_i=0 with cs_n_i=1 has no effect.
- R4: With parity_en_i=1, the bit after the data is a parity bit. With odd_parity_i=1 the data bits and the parity bit together must hold an odd number of ones; with odd_parity_i=0 they must hold an even number. A mismatch sets parity_err_o to 1.
- R5: If a frame completes while rx_full_o is 1 and no read is made in that cycle, overflow_o is set to 1, data_o keeps the earlier byte and the new byte is discarded.
- R6: A read strobe (rd_n_i=0 and cs_n_i=0) clears rx_full_o, parity_err_o and overflow_o together on the next clock edge.
- R7: With eight_bit_i=0, a frame carries 7 data bits and data_o[7] is loaded as 0; with eight_bit_i=1 it carries 8 data bits.
- R8: With sync_mode_i=0, one bit lasts 16*baud_val_i clocks (a baud_val_i of 0 acts as 1). A START bit is accepted only if the line is still low at its middle (the 8th tick); otherwise the low pulse is ignored.
- R9: With sync_mode_i=1, a falling edge of the synchronised line starts a frame, and each following clock samples one bit.
- R10: With parity_en_i=0, no parity bit is expected and parity_err_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | 1: one bit per clock; 0: 16x oversampled |
| baud_val_i | input | BAUD_W | Clocks per oversample tick in asynchronous mode |
| eight_bit_i | input | 1 | 1: 8 data bits; 0: 7 data bits |
| parity_en_i | input | 1 | Parity bit present and checked |
| odd_parity_i | input | 1 | 1: odd parity; 0: even parity |
| rx_i | input | 1 | Serial data in, idle high |
| rd_n_i | input | 1 | Read enable, active low |
| cs_n_i | input | 1 | Chip select, active low, qualifies rd_n_i |
| data_o | output | DATA_W | Received byte in the hold register |
| rx_full_o | output | 1 | Hold register holds unread data |
| parity_err_o | output | 1 | Sticky parity mismatch flag |
| overflow_o | output | 1 | Sticky overrun flag |

## Verification
The bench uses the default parameters: DATA_W=8, OS_RATE=16, BAUD_W=8. It changes only the run-time inputs. Synchronous mode gives frames a few clocks long, so the bench can cover 8-bit and 7-bit data, both parity senses, parity errors and overrun cheaply. In asynchronous mode, baud_val_i values of 2 and 0 keep a bit period at 32 and 16 clocks. That is short enough to run full oversampled frames and a sub-half-bit glitch on the START bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_s_o,
  output logic rx_fall_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= rx_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rx_s_o    = s2_q;
  assign rx_fall_o = s3_q & ~s2_q;
endmodule

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int BAUD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_mode_i,
  input  logic [BAUD_W-1:0] baud_val_i,
  output logic              tick_o
);
  logic [BAUD_W-1:0] cnt_q;
  logic [BAUD_W-1:0] lim;
  logic              wrap;

  // a divisor of 0 behaves as 1
  assign lim    = (baud_val_i == '0) ? '0 : baud_val_i - BAUD_W'(1);
  assign wrap   = (cnt_q >= lim);
  assign tick_o = sync_mode_i | wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + BAUD_W'(1);
  end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_mode_i,
  input  logic              tick_i,
  input  logic              rx_s_i,
  input  logic              rx_fall_i,
  input  logic              eight_bit_i,
  input  logic              parity_en_i,
  input  logic              odd_parity_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o
);
  localparam int SC_W  = $clog2(OS_RATE);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [SC_W-1:0]  SC_MID  = SC_W'(OS_RATE/2 - 1);
  localparam logic [SC_W-1:0]  SC_END  = SC_W'(OS_RATE - 1);
  localparam logic [IDX_W-1:0] LAST_W8 = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] LAST_W7 = IDX_W'(DATA_W - 2);

  rx_state_e         state_q;
  logic [SC_W-1:0]   sc_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              acc_q, perr_q, done_q;
  logic              mid_hit, end_hit;
  logic [IDX_W-1:0]  last_idx;

  assign mid_hit  = tick_i && (sc_q == SC_MID);
  assign end_hit  = sync_mode_i | (tick_i && (sc_q == SC_END));
  assign last_idx = eight_bit_i ? LAST_W8 : LAST_W7;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      sc_q    <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      acc_q   <= 1'b0;
      perr_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q != RX_IDLE && tick_i) sc_q <= sc_q + SC_W'(1);
      unique case (state_q)
        RX_IDLE: begin
          if (rx_fall_i) begin
            sc_q    <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            acc_q   <= 1'b0;
            perr_q  <= 1'b0;
            state_q <= sync_mode_i ? RX_DATA : RX_START;
          end
        end
        RX_START: begin
          if (mid_hit) begin
            sc_q    <= '0;
            state_q <= rx_s_i ? RX_IDLE : RX_DATA;  // glitch rejected
          end
        end
        RX_DATA: begin
          if (end_hit) begin
            sc_q           <= '0;
            shreg_q[idx_q] <= rx_s_i;
            acc_q          <= acc_q ^ rx_s_i;
            idx_q          <= idx_q + IDX_W'(1);
            if (idx_q == last_idx) state_q <= parity_en_i ? RX_PARITY : RX_STOP;
          end
        end
        RX_PARITY: begin
          if (end_hit) begin
            sc_q    <= '0;
            perr_q  <= acc_q ^ rx_s_i ^ odd_parity_i;
            state_q <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (end_hit) begin
            sc_q    <= '0;
            done_q  <= 1'b1;
            state_q <= RX_IDLE;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign data_o = shreg_q;
  assign perr_o = perr_q;
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] frame_data_i,
  input  logic              frame_perr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              perr_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] data_q;
  logic              full_q, perr_q, ovf_q;
  logic              accept, drop;

  // a read in the same cycle frees the register for the new frame
  assign accept = done_i & (~full_q | rd_i);
  assign drop   = done_i & full_q & ~rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      perr_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (accept) data_q <= frame_data_i;
      full_q <= accept | (full_q & ~rd_i);
      perr_q <= (accept & frame_perr_i) | (perr_q & ~rd_i);
      ovf_q  <= drop | (ovf_q & ~rd_i);
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign perr_o = perr_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16,
  parameter int BAUD_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_mode_i,
  input  logic [BAUD_W-1:0] baud_val_i,
  input  logic              eight_bit_i,
  input  logic              parity_en_i,
  input  logic              odd_parity_i,
  input  logic              rx_i,
  input  logic              rd_n_i,
  input  logic              cs_n_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rx_full_o,
  output logic              parity_err_o,
  output logic              overflow_o
);
  logic              rx_s, rx_fall, tick;
  logic              frame_done, frame_perr, rd;
  logic [DATA_W-1:0] frame_data;

  assign rd = ~rd_n_i & ~cs_n_i;

  uart_rx_sync i_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_i      (rx_i),
    .rx_s_o    (rx_s),
    .rx_fall_o (rx_fall)
  );

  uart_rx_baud #(.BAUD_W(BAUD_W)) i_baud (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_mode_i (sync_mode_i),
    .baud_val_i  (baud_val_i),
    .tick_o      (tick)
  );

  uart_rx_frame #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) i_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sync_mode_i  (sync_mode_i),
    .tick_i       (tick),
    .rx_s_i       (rx_s),
    .rx_fall_i    (rx_fall),
    .eight_bit_i  (eight_bit_i),
    .parity_en_i  (parity_en_i),
    .odd_parity_i (odd_parity_i),
    .done_o       (frame_done),
    .data_o       (frame_data),
    .perr_o       (frame_perr)
  );

  uart_rx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .done_i       (frame_done),
    .frame_data_i (frame_data),
    .frame_perr_i (frame_perr),
    .rd_i         (rd),
    .data_o       (data_o),
    .full_o       (rx_full_o),
    .perr_o       (parity_err_o),
    .ovf_o        (overflow_o)
  );
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_n_i,
  input logic              cs_n_i,
  input logic              parity_en_i,
  input logic              eight_bit_i,
  input logic              frame_done,
  input logic [DATA_W-1:0] data_o,
  input logic              rx_full_o,
  input logic              parity_err_o,
  input logic              overflow_o
);
  logic rd_c;
  assign rd_c = ~rd_n_i & ~cs_n_i;

  AST_DONE_SETS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done |=> rx_full_o);  // R2
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_o && !rd_c) |=> rx_full_o);  // R3
  AST_PERR_NEEDS_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(parity_err_o) |-> $past(parity_en_i));  // R4
  AST_OVF_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(rx_full_o));  // R5
  AST_OVF_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_o && !rd_c) |=> $stable(data_o));  // R5
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_c && !frame_done) |=> (!rx_full_o && !parity_err_o && !overflow_o));  // R6
  AST_BIT7_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && !eight_bit_i && !(rx_full_o && !rd_c)) |=> !data_o[DATA_W-1]);  // R7
endmodule

bind uart_rx_core uart_rx_core_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_n_i       (rd_n_i),
  .cs_n_i       (cs_n_i),
  .parity_en_i  (parity_en_i),
  .eight_bit_i  (eight_bit_i),
  .frame_done   (frame_done),
  .data_o       (data_o),
  .rx_full_o    (rx_full_o),
  .parity_err_o (parity_err_o),
  .overflow_o   (overflow_o)
);

// File: tb/test_uart_rx_core.sv
module test_uart_rx_core;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_mode = 1'b1;
  logic [7:0] baud_val = 8'd1;
  logic       eight_bit = 1'b1, parity_en = 1'b0, odd_parity = 1'b0;
  logic       rx = 1'b1, rd_n = 1'b1, cs_n = 1'b1;
  logic [7:0] data;
  logic       full, perr, ovf;
  int         n_checks = 0, n_fail = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_core i_uart_rx_core (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sync_mode_i  (sync_mode),
    .baud_val_i   (baud_val),
    .eight_bit_i  (eight_bit),
    .parity_en_i  (parity_en),
    .odd_parity_i (odd_parity),
    .rx_i         (rx),
    .rd_n_i       (rd_n),
    .cs_n_i       (cs_n),
    .data_o       (data),
    .rx_full_o    (full),
    .parity_err_o (perr),
    .overflow_o   (ovf)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // period: clocks per bit (1 in synchronous mode)
  task automatic send_frame(input logic [7:0] b, input int period, input bit bad_par);
    int  nb = eight_bit ? 8 : 7;
    logic p = odd_parity;
    for (int i = 0; i < nb; i++) p ^= b[i];
    if (bad_par) p = ~p;
    rx = 1'b0;
    repeat (period) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx = b[i];
      repeat (period) @(negedge clk);
    end
    if (parity_en) begin
      rx = p;
      repeat (period) @(negedge clk);
    end
    rx = 1'b1;
    repeat (period + 8) @(negedge clk);
  endtask

  task automatic do_read();
    rd_n = 1'b0; cs_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 data", data, 0);
    check("R1 full", full, 0);
    check("R1 perr", perr, 0);
    check("R1 ovf", ovf, 0);
    repeat (20) @(negedge clk);
    check("R1 idle line no frame", full, 0);
  endtask

  task automatic t_sync_basic();
    sync_mode = 1'b1; eight_bit = 1'b1; parity_en = 1'b0;
    send_frame(8'hA5, 1, 1'b0);
    check("R2 R9 data", data, 8'hA5);
    check("R2 full", full, 1);
    check("R10 no perr", perr, 0);
    rd_n = 1'b0; cs_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk);
    check("R3 cs_n high ignored", full, 1);
    do_read();
    check("R6 read clears full", full, 0);
  endtask

  task automatic t_parity();
    parity_en = 1'b1; odd_parity = 1'b0;
    send_frame(8'h3C, 1, 1'b0);
    check("R4 even good data", data, 8'h3C);
    check("R4 even good perr", perr, 0);
    do_read();
    odd_parity = 1'b1;
    send_frame(8'h81, 1, 1'b1);
    check("R4 odd bad data", data, 8'h81);
    check("R4 odd bad perr", perr, 1);
    do_read();
    check("R6 read clears perr", perr, 0);
    send_frame(8'h07, 1, 1'b0);
    check("R4 odd good perr", perr, 0);
    do_read();
  endtask

  task automatic t_overflow();
    parity_en = 1'b0;
    send_frame(8'h11, 1, 1'b0);
    send_frame(8'h22, 1, 1'b0);
    check("R5 old byte kept", data, 8'h11);
    check("R5 ovf set", ovf, 1);
    check("R5 full", full, 1);
    do_read();
    check("R6 ovf cleared", ovf, 0);
    check("R6 full cleared", full, 0);
  endtask

  task automatic t_seven_bit();
    eight_bit = 1'b0; parity_en = 1'b1; odd_parity = 1'b0;
    send_frame(8'hD5, 1, 1'b0);
    check("R7 seven-bit data", data, 8'h55);
    check("R7 seven-bit perr", perr, 0);
    do_read();
    eight_bit = 1'b1;
  endtask

  task automatic t_async();
    sync_mode = 1'b0; baud_val = 8'd2;
    parity_en = 1'b1; odd_parity = 1'b1;
    repeat (4) @(negedge clk);
    send_frame(8'h96, 32, 1'b0);
    check("R8 async data", data, 8'h96);
    check("R8 async full", full, 1);
    check("R4 async perr", perr, 0);
    do_read();
    // low pulse shorter than half a bit
    rx = 1'b0;
    repeat (4) @(negedge clk);
    rx = 1'b1;
    repeat (400) @(negedge clk);
    check("R8 glitch ignored", full, 0);
    baud_val = 8'd0; parity_en = 1'b0;
    send_frame(8'h5A, 16, 1'b0);
    check("R8 divisor zero data", data, 8'h5A);
    check("R10 async no parity", perr, 0);
    do_read();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sync_basic();
    t_parity();
    t_overflow();
    t_seven_bit();
    t_async();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule